// File: doc/BRIEF.md
# Secure Illegal-Access Interrupt Controller

This block gathers single-cycle illegal-access event pulses from a set of protected peripherals and memories. It holds each one in a sticky flag and raises one secure interrupt line whenever a flag whose source is enabled is set. Software reaches three word registers through a small register bus. The first holds a per-source interrupt enable mask. The second is a read-only status view that shows each flag ANDed with its enable. The third is a write-one-to-clear port that drops selected flags.

The register bus carries a secure qualifier and a privileged qualifier. An access goes through only when both qualifiers are high and the system-level security enable input is high as well. Any other access is refused. A refused access reads as zero, changes nothing, and produces a one-cycle error pulse. A typical interrupt handler reads the masked status and writes that value back to the clear register. That removes exactly the events it has seen, and an event that arrives on another source in the meantime stays pending.

Every register access is sampled on a rising clock edge. Read data and the error flag appear one cycle later, and they hold until the next edge. The bus offsets, as byte addresses, are 0x0 for enable, 0x4 for masked status and 0x8 for clear.

Top module: `secure_fault_irq`

## Requirements
- R1: After synchronous reset, all flags and enable bits are zero, irq_out is low, bus_err is low, and reads of offsets 0x0 and 0x4 return zero.
- R2: An accepted write to offset 0x0 loads bit i of the data into enable bit i for the NUM_SRC low bits, and a read of 0x0 returns that mask with the upper bits zero. Writing all ones enables every source, and writing zero disables every source.
- R3: A pulse on evt_in[i] sets flag i even while enable bit i is clear. Bit i of a read of offset 0x4 is one only when flag i and enable bit i are both set, so enabling the source later exposes the event.
- R4: An accepted write to offset 0x8 clears flag i for every data bit i that is one. Bits written as zero leave their flags unchanged.
- R5: When evt_in[i] pulses in the same cycle as a clear of bit i, flag i remains set.
- R6: irq_out is high exactly while some masked status bit is set.
- R7: An access with bus_secure low or bus_priv low is refused. A refused write changes no state. A refused read returns zero. bus_err is high for the single cycle after each refused access and low after accepted or idle cycles.
- R8: While sys_sec_en is low, every access is refused as in R7, even when it is secure and privileged.
- R9: Writes to offset 0x4 change neither flags nor enables, and reads of offset 0x8 return zero.
- R10: Writing back the value read from offset 0x4 to offset 0x8 clears exactly those flags, while an event arriving on another source in that same write cycle stays latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_sec_en | input | 1 | System security enable; low locks out the register bus |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Transaction is secure |
| bus_priv | input | 1 | Transaction is privileged |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | One-cycle refusal pulse, one cycle after the request |
| evt_in | input | NUM_SRC | Illegal-access event pulses, one per source |
| irq_out | output | 1 | Secure interrupt request |

## Verification
The bench drives a clear and a new event onto the same source in one cycle. A design that gives the clear priority would lose that event and drop irq_out. The bench also latches events while their sources are disabled and then enables them. A flag gated by the enable at capture time would never show up in status.

The handler write-back is paired with a fresh event on a different bit. A whole-register clear would wipe that event out. Refused accesses are tried with each qualifier missing and with security disabled. A leaky gate would show up as an altered enable readback, non-zero read data, or a missing or stretched error pulse. The read-only status register and the write-only clear register are probed to catch decode aliasing.

// File: rtl/secure_fault_irq_pkg.sv
package secure_fault_irq_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_ENABLE = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 4'h8;

    typedef enum logic [1:0] {
        SEL_ENABLE,
        SEL_STATUS,
        SEL_CLEAR,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic              act;
        logic              wr;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_ENABLE: s = SEL_ENABLE;
            OFS_STATUS: s = SEL_STATUS;
            OFS_CLEAR:  s = SEL_CLEAR;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic access_allowed(input logic sys_en, input logic sec,
                                            input logic priv);
        return sys_en & sec & priv;
    endfunction

endpackage

// File: rtl/secure_fault_irq_gate.sv
module secure_fault_irq_gate
    import secure_fault_irq_pkg::*;
(
    input  logic              sys_sec_en,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_secure,
    input  logic              bus_priv,
    output bus_req_t          req,
    output logic              reject
);
    logic allowed;

    always_comb begin
        allowed   = access_allowed(sys_sec_en, bus_secure, bus_priv);
        req.act   = bus_valid & allowed;
        req.wr    = bus_write;
        req.sel   = decode_offset(bus_addr);
        req.wdata = bus_wdata;
        reject    = bus_valid & ~allowed;
    end
endmodule

// File: rtl/secure_fault_irq_flags.sv
module secure_fault_irq_flags #(
    parameter int NUM_SRC = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] flag
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)
                flag[i] <= 1'b0;
            else if (evt[i])
                flag[i] <= 1'b1;    // a fresh event beats a clear
            else if (clr_mask[i])
                flag[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/secure_fault_irq_enable.sv
module secure_fault_irq_enable #(
    parameter int NUM_SRC = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [NUM_SRC-1:0] value,
    output logic [NUM_SRC-1:0] en
);
    always_ff @(posedge clk) begin
        if (rst)
            en <= '0;
        else if (load)
            en <= value;
    end
endmodule

// File: rtl/secure_fault_irq.sv
module secure_fault_irq
    import secure_fault_irq_pkg::*;
#(
    parameter int NUM_SRC = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sys_sec_en,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [3:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic               bus_secure,
    input  logic               bus_priv,
    output logic [31:0]        bus_rdata,
    output logic               bus_err,
    input  logic [NUM_SRC-1:0] evt_in,
    output logic               irq_out
);
    bus_req_t           req;
    logic               reject;
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] masked;
    logic [NUM_SRC-1:0] clr_mask;
    logic               en_load;
    logic [DATA_W-1:0]  rd_next;
    logic [DATA_W-1:0]  rdata_q;
    logic               err_q;

    secure_fault_irq_gate u_gate (
        .sys_sec_en (sys_sec_en),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_secure (bus_secure),
        .bus_priv   (bus_priv),
        .req        (req),
        .reject     (reject)
    );

    always_comb begin
        en_load  = req.act & req.wr & (req.sel == SEL_ENABLE);
        clr_mask = (req.act & req.wr & (req.sel == SEL_CLEAR)) ?
                   req.wdata[NUM_SRC-1:0] : '0;
        masked   = flag_q & en_q;
    end

    secure_fault_irq_enable #(.NUM_SRC(NUM_SRC)) u_enable (
        .clk   (clk),
        .rst   (rst),
        .load  (en_load),
        .value (req.wdata[NUM_SRC-1:0]),
        .en    (en_q)
    );

    secure_fault_irq_flags #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_in),
        .clr_mask (clr_mask),
        .flag     (flag_q)
    );

    always_comb begin
        rd_next = '0;
        if (req.act && !req.wr) begin
            case (req.sel)
                SEL_ENABLE: rd_next[NUM_SRC-1:0] = en_q;
                SEL_STATUS: rd_next[NUM_SRC-1:0] = masked;
                default:    rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= rd_next;
            err_q   <= reject;
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;
    assign irq_out   = |masked;
endmodule

// File: rtl/secure_fault_irq_chk.sv
module secure_fault_irq_chk #(
    parameter int NUM_SRC = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               sys_sec_en,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [3:0]         bus_addr,
    input logic               bus_secure,
    input logic               bus_priv,
    input logic [31:0]        bus_rdata,
    input logic               bus_err,
    input logic [NUM_SRC-1:0] evt_in,
    input logic [NUM_SRC-1:0] flag_q,
    input logic [NUM_SRC-1:0] en_q
);
    logic ok;
    assign ok = sys_sec_en & bus_secure & bus_priv;

    // R7
    refused_err_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !ok) |=> bus_err);

    // R7
    err_pulse_only_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && !ok) |=> !bus_err);

    // R8
    refused_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && !ok) |=> (bus_rdata == 32'h0));

    // R2
    enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && bus_write && ok && bus_addr == 4'h0) |=> $stable(en_q));

    // R5
    event_latches_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_in != '0) |=> ((flag_q & $past(evt_in)) == $past(evt_in)));

    // R4
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        ((flag_q & ~$past(flag_q) & ~$past(evt_in)) == '0));
endmodule

bind secure_fault_irq secure_fault_irq_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sys_sec_en (sys_sec_en),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_secure (bus_secure),
    .bus_priv   (bus_priv),
    .bus_rdata  (bus_rdata),
    .bus_err    (bus_err),
    .evt_in     (evt_in),
    .flag_q     (flag_q),
    .en_q       (en_q)
);

// File: tb/secure_fault_irq_bench.sv
module secure_fault_irq_bench;
    localparam int N = 12;
    localparam logic [31:0] ALL = 32'h0000_0FFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sys_sec_en = 1'b1;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_secure = 1'b0;
    logic          bus_priv = 1'b0;
    logic [31:0]   bus_rdata;
    logic          bus_err;
    logic [N-1:0]  evt_in = '0;
    logic          irq_out;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rd;
    logic        er;

    secure_fault_irq #(.NUM_SRC(N)) u_secure_fault_irq (
        .clk(clk), .rst(rst), .sys_sec_en(sys_sec_en),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_secure(bus_secure), .bus_priv(bus_priv),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .evt_in(evt_in),
        .irq_out(irq_out)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [3:0] a, input logic [31:0] d,
                          input logic sec, input logic priv, input logic [N-1:0] ev);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        bus_secure = sec; bus_priv = priv; evt_in = ev;
        @(posedge clk);
        #1;
        rd = bus_rdata; er = bus_err;
        bus_valid = 1'b0; evt_in = '0;
    endtask

    task automatic wr_ok(input logic [3:0] a, input logic [31:0] d);
        access(1'b1, a, d, 1'b1, 1'b1, '0);
    endtask

    task automatic rd_ok(input logic [3:0] a);
        access(1'b0, a, 32'h0, 1'b1, 1'b1, '0);
    endtask

    task automatic pulse(input logic [N-1:0] m);
        @(negedge clk);
        evt_in = m;
        @(posedge clk);
        #1 evt_in = '0;
    endtask

    task automatic t_reset;
        check("R1 irq", {31'h0, irq_out}, 32'h0);
        check("R1 err", {31'h0, bus_err}, 32'h0);
        rd_ok(4'h0); check("R1 enable", rd, 32'h0);
        rd_ok(4'h4); check("R1 status", rd, 32'h0);
    endtask

    task automatic t_enable;
        wr_ok(4'h0, 32'hFFFF_FFFF); rd_ok(4'h0); check("R2 all ones", rd, ALL);
        wr_ok(4'h0, 32'h0);         rd_ok(4'h0); check("R2 zero", rd, 32'h0);
        wr_ok(4'h0, 32'h0A5);       rd_ok(4'h0); check("R2 pattern", rd, 32'h0A5);
    endtask

    task automatic t_latch_disabled;
        wr_ok(4'h0, 32'h0);
        pulse(12'h004);
        rd_ok(4'h4); check("R3 masked while disabled", rd, 32'h0);
        check("R6 irq low while disabled", {31'h0, irq_out}, 32'h0);
        wr_ok(4'h0, 32'h004);
        rd_ok(4'h4); check("R3 visible after enable", rd, 32'h004);
        check("R6 irq high", {31'h0, irq_out}, 32'h1);
    endtask

    task automatic t_clear;
        wr_ok(4'h0, ALL);
        pulse(12'h081);
        rd_ok(4'h4); check("R4 three flags", rd, 32'h085);
        wr_ok(4'h8, 32'h0); rd_ok(4'h4); check("R4 zero write no effect", rd, 32'h085);
        wr_ok(4'h8, 32'h005); rd_ok(4'h4); check("R4 partial clear", rd, 32'h080);
        check("R6 irq still high", {31'h0, irq_out}, 32'h1);
        wr_ok(4'h8, 32'h080); rd_ok(4'h4); check("R4 all cleared", rd, 32'h0);
        check("R6 irq low", {31'h0, irq_out}, 32'h0);
    endtask

    task automatic t_race;
        access(1'b1, 4'h8, 32'h010, 1'b1, 1'b1, 12'h010);
        rd_ok(4'h4); check("R5 event wins over clear", rd, 32'h010);
        check("R5 irq stays", {31'h0, irq_out}, 32'h1);
        wr_ok(4'h8, ALL);
    endtask

    task automatic t_handler;
        logic [31:0] seen;
        pulse(12'h00A);
        rd_ok(4'h4); seen = rd; check("R10 snapshot", seen, 32'h00A);
        access(1'b1, 4'h8, seen, 1'b1, 1'b1, 12'h020);
        rd_ok(4'h4); check("R10 new event kept", rd, 32'h020);
        wr_ok(4'h8, ALL);
    endtask

    task automatic t_reject;
        wr_ok(4'h0, 32'h003);
        access(1'b1, 4'h0, ALL, 1'b0, 1'b1, '0);
        check("R7 nonsecure write err", {31'h0, er}, 32'h1);
        @(posedge clk); #1;
        check("R7 err one cycle", {31'h0, bus_err}, 32'h0);
        access(1'b1, 4'h0, ALL, 1'b1, 1'b0, '0);
        check("R7 unpriv write err", {31'h0, er}, 32'h1);
        access(1'b0, 4'h0, 32'h0, 1'b1, 1'b0, '0);
        check("R7 unpriv read zero", rd, 32'h0);
        check("R7 unpriv read err", {31'h0, er}, 32'h1);
        rd_ok(4'h0); check("R7 enable unchanged", rd, 32'h003);
        check("R7 no err on accepted", {31'h0, er}, 32'h0);
    endtask

    task automatic t_syssec;
        sys_sec_en = 1'b0;
        access(1'b1, 4'h0, ALL, 1'b1, 1'b1, '0);
        check("R8 write err", {31'h0, er}, 32'h1);
        access(1'b0, 4'h0, 32'h0, 1'b1, 1'b1, '0);
        check("R8 read zero", rd, 32'h0);
        check("R8 read err", {31'h0, er}, 32'h1);
        sys_sec_en = 1'b1;
        rd_ok(4'h0); check("R8 enable unchanged", rd, 32'h003);
    endtask

    task automatic t_readonly;
        pulse(12'h001);
        wr_ok(4'h4, ALL);
        rd_ok(4'h4); check("R9 status write ignored", rd, 32'h001);
        rd_ok(4'h0); check("R9 enable unaffected", rd, 32'h003);
        rd_ok(4'h8); check("R9 clear reads zero", rd, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        t_reset();
        t_enable();
        t_latch_disabled();
        t_clear();
        t_race();
        t_handler();
        t_reject();
        t_syssec();
        t_readonly();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule